// File: doc/BRIEF.md
# Iterative Single-Precision Divider

This unit divides one 32-bit single-precision operand by another over many clock cycles. A one-cycle `start` pulse captures both operands. The unit splits each operand into sign, biased exponent and significand, and restores the hidden leading one. It forms the result exponent from the difference of the two exponents. It then runs a non-restoring shift-and-subtract loop that produces one quotient bit per cycle, 26 bits in all.

After the last step, the unit corrects a negative final remainder and folds it into a sticky bit. It shifts the quotient left by at most one place to normalize it, then rounds to nearest. The packed result is presented with a one-cycle `done` pulse.

An operand that is subnormal, infinite or not-a-number, and a zero divisor, skip the loop and finish on the next cycle. Each of these cases, and an exponent that leaves the normal range, is reported on its own flag. `busy` is high for the whole of an operation, and a `start` that arrives while `busy` is high has no effect.

Top module: `fdiv_unit`

## Requirements
- R1: The result sign is the XOR of the operand signs (bit 31). The biased result exponent is the dividend exponent (bits 30:23) minus the divisor exponent plus 127, reduced by one when the significand ratio is below one.
- R2: An operation on two nonzero normal operands uses 26 non-restoring iterations. `done` rises exactly 27 clock edges after the edge that accepted `start`.
- R3: The 24-bit result significand is rounded to nearest. It is incremented when the guard bit is set and either the sticky bit or the result LSB is set. The sticky bit is the OR of the quotient bits below the guard bit and of a nonzero corrected remainder. A carry out of rounding gives significand 1.0 and raises the exponent by one.
- R4: If the first quotient bit (weight 1) is 0, the quotient is shifted left once before rounding. Otherwise it is used as is.
- R5: A zero dividend with a nonzero normal divisor returns a zero with the XOR sign, raises no flag, and finishes one edge after acceptance.
- R6: A zero divisor with a zero or normal dividend raises `excDivZero` and returns 0x7FC00000, one edge after acceptance. At most one flag is high at any time.
- R7: An operand with exponent 255, or with exponent 0 and a nonzero fraction, raises `excInvalid` and returns 0x7FC00000, one edge after acceptance. This case takes priority over R6 and R5.
- R8: If the rounded biased exponent is 255 or more, `excOverflow` is raised and the result is a signed infinity (bits 30:0 = 0x7F800000).
- R9: If the rounded biased exponent is 0 or less, `excUnderflow` is raised and the result is a signed zero.
- R10: `busy` is high from the edge after `start` is accepted until the edge that raises `done`. `done` is a one-cycle pulse. A `start` seen while `busy` is high changes neither the result nor the timing.
- R11: After reset, `busy`, `done`, `quotient` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the operands (when idle) |
| dividend | input | 32 | Numerator, single precision |
| divisor | input | 32 | Denominator, single precision |
| quotient | output | 32 | Packed result, held until the next result |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Operation in progress |
| excInvalid | output | 1 | Subnormal, infinite or NaN operand |
| excDivZero | output | 1 | Zero divisor |
| excOverflow | output | 1 | Result exponent too large |
| excUnderflow | output | 1 | Result exponent too small |

## Verification
The bench aims at both normalization paths: ratios above and below one. A design that mishandles one of them returns a value off by a factor of two, or with an exponent off by one.

It runs operands whose last quotient bits and remainder decide the rounding. A missing remainder correction or a lost sticky bit would round some of these down. It also probes the exponent edges just inside and just outside the normal range, where a comparison off by one would raise a false flag or miss a real one.

For special operands, it checks the priority and the one-cycle latency. A second `start` is fired in the middle of a divide: a unit that restarted on it would finish late or return the wrong quotient.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  parameter int ExpW     = 8;
  parameter int FracW    = 23;
  parameter int WordW    = 1 + ExpW + FracW;
  parameter int SigW     = FracW + 1;
  parameter int QuoW     = SigW + 2;
  parameter int RemW     = SigW + 3;
  parameter int Bias     = (1 << (ExpW - 1)) - 1;
  parameter int ExpMax   = (1 << ExpW) - 1;
  parameter int CntW     = $clog2(QuoW + 1);
  parameter int ExpCalcW = ExpW + 3;

  typedef enum logic [1:0] {OpNormal, OpInvalid, OpDivZero, OpZero} op_class_e;
  typedef enum logic [1:0] {StIdle, StIter, StFinish} state_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctl_s;
endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic special,
  output ctl_s ctl,
  output logic busy,
  output logic done
);
  state_e state;
  logic [CntW-1:0] iterCnt;

  always_comb begin
    ctl = '0;
    case (state)
      StIdle:   ctl.load = start;
      StIter:   ctl.step = 1'b1;
      StFinish: ctl.finish = 1'b1;
      default:  ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= StIdle;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        StIdle: if (start) begin
          state   <= special ? StFinish : StIter;
          iterCnt <= '0;
        end
        StIter: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == CntW'(QuoW - 1)) state <= StFinish;
        end
        StFinish: begin
          done  <= 1'b1;
          state <= StIdle;
        end
        default: state <= StIdle;
      endcase
    end
  end

  assign busy = (state != StIdle);

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_s             ctl,
  input  logic [WordW-1:0] dividend,
  input  logic [WordW-1:0] divisor,
  output logic             special,
  output logic [WordW-1:0] quotient,
  output logic             excInvalid,
  output logic             excDivZero,
  output logic             excOverflow,
  output logic             excUnderflow
);
  localparam logic [WordW-1:0] QNaN   = {1'b0, {ExpW{1'b1}}, 1'b1, {(FracW-1){1'b0}}};
  localparam logic [WordW-2:0] InfMag = {{ExpW{1'b1}}, {FracW{1'b0}}};

  // operand classification
  logic [ExpW-1:0]  expA, expB;
  logic [FracW-1:0] fracA, fracB;
  logic aZero, bZero, aBad, bBad;
  op_class_e cls;

  assign expA  = dividend[WordW-2 -: ExpW];
  assign expB  = divisor[WordW-2 -: ExpW];
  assign fracA = dividend[FracW-1:0];
  assign fracB = divisor[FracW-1:0];

  always_comb begin
    aZero = (expA == '0) && (fracA == '0);
    bZero = (expB == '0) && (fracB == '0);
    aBad  = ((expA == '0) && (fracA != '0)) || (expA == ExpW'(ExpMax));
    bBad  = ((expB == '0) && (fracB != '0)) || (expB == ExpW'(ExpMax));
    if (aBad || bBad)  cls = OpInvalid;
    else if (bZero)    cls = OpDivZero;
    else if (aZero)    cls = OpZero;
    else               cls = OpNormal;
  end
  assign special = (cls != OpNormal);

  // working registers
  op_class_e                   clsR;
  logic                        signR;
  logic signed [ExpCalcW-1:0]  expR;
  logic [SigW-1:0]             divR;
  logic [RemW-1:0]             rem;
  logic [QuoW-1:0]             quo;

  // one non-restoring step
  logic [RemW-1:0] divExt, trial;
  assign divExt = {{(RemW-SigW){1'b0}}, divR};
  assign trial  = rem[RemW-1] ? (rem + divExt) : (rem - divExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsR  <= OpNormal;
      signR <= 1'b0;
      expR  <= '0;
      divR  <= '0;
      rem   <= '0;
      quo   <= '0;
    end else if (ctl.load) begin
      clsR  <= cls;
      signR <= dividend[WordW-1] ^ divisor[WordW-1];
      expR  <= ExpCalcW'(expA) - ExpCalcW'(expB) + ExpCalcW'(Bias);
      divR  <= {1'b1, fracB};
      rem   <= {{(RemW-SigW){1'b0}}, 1'b1, fracA};
      quo   <= '0;
    end else if (ctl.step) begin
      quo <= {quo[QuoW-2:0], ~trial[RemW-1]};
      rem <= {trial[RemW-2:0], 1'b0};
    end
  end

  // remainder correction, normalization, rounding
  logic [RemW-1:0]            remFix;
  logic                       topBit, guard, sticky, roundUp, carry;
  logic [SigW-1:0]            mant;
  logic [SigW:0]              mantRnd;
  logic signed [ExpCalcW-1:0] expNorm, expFin;
  logic [FracW-1:0]           fracOut;
  logic                       ovf, unf;

  always_comb begin
    remFix  = rem[RemW-1] ? (rem + {divExt[RemW-2:0], 1'b0}) : rem;
    topBit  = quo[QuoW-1];
    if (topBit) begin
      mant    = quo[QuoW-1:2];
      guard   = quo[1];
      sticky  = quo[0] | (|remFix);
      expNorm = expR;
    end else begin
      mant    = quo[QuoW-2:1];
      guard   = quo[0];
      sticky  = |remFix;
      expNorm = expR - ExpCalcW'(1);
    end
    roundUp = guard & (sticky | mant[0]);
    mantRnd = {1'b0, mant} + {{SigW{1'b0}}, roundUp};
    carry   = mantRnd[SigW];
    expFin  = expNorm + ExpCalcW'(carry);
    fracOut = carry ? '0 : mantRnd[FracW-1:0];
    ovf     = expFin >= ExpCalcW'(ExpMax);
    unf     = expFin <= ExpCalcW'(0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient     <= '0;
      excInvalid   <= 1'b0;
      excDivZero   <= 1'b0;
      excOverflow  <= 1'b0;
      excUnderflow <= 1'b0;
    end else if (ctl.finish) begin
      excInvalid   <= 1'b0;
      excDivZero   <= 1'b0;
      excOverflow  <= 1'b0;
      excUnderflow <= 1'b0;
      case (clsR)
        OpInvalid: begin
          quotient   <= QNaN;
          excInvalid <= 1'b1;
        end
        OpDivZero: begin
          quotient   <= QNaN;
          excDivZero <= 1'b1;
        end
        OpZero: quotient <= {signR, {(WordW-1){1'b0}}};
        default: begin
          if (ovf) begin
            quotient    <= {signR, InfMag};
            excOverflow <= 1'b1;
          end else if (unf) begin
            quotient     <= {signR, {(WordW-1){1'b0}}};
            excUnderflow <= 1'b1;
          end else begin
            quotient <= {signR, expFin[ExpW-1:0], fracOut};
          end
        end
      endcase
    end
  end

  assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excInvalid, excDivZero, excOverflow, excUnderflow}));
  assert_nan_on_exc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (excInvalid || excDivZero) |-> (quotient == QNaN));
  assert_inf_on_ovf_R8: assert property (@(posedge clk) disable iff (!rstN)
    excOverflow |-> (quotient[WordW-2:0] == InfMag));
  assert_zero_on_unf_R9: assert property (@(posedge clk) disable iff (!rstN)
    excUnderflow |-> (quotient[WordW-2:0] == '0));
  assert_quo_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.finish) |=> $stable(quotient));
endmodule

// File: rtl/fdiv_unit.sv
module fdiv_unit
  import fdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] dividend,
  input  logic [31:0] divisor,
  output logic [31:0] quotient,
  output logic        done,
  output logic        busy,
  output logic        excInvalid,
  output logic        excDivZero,
  output logic        excOverflow,
  output logic        excUnderflow
);
  ctl_s ctl;
  logic special;

  fdiv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .special(special),
    .ctl(ctl), .busy(busy), .done(done)
  );

  fdiv_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .dividend(dividend), .divisor(divisor), .special(special),
    .quotient(quotient), .excInvalid(excInvalid), .excDivZero(excDivZero),
    .excOverflow(excOverflow), .excUnderflow(excUnderflow)
  );
endmodule

// File: tb/test_fdiv_unit.sv
module test_fdiv_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic [31:0] quotient;
  logic done, busy, excInvalid, excDivZero, excOverflow, excUnderflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int unsigned seed = 32'h1234_5677;

  always #2 clk = ~clk;

  fdiv_unit i_fdiv_unit (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .done(done), .busy(busy), .excInvalid(excInvalid),
    .excDivZero(excDivZero), .excOverflow(excOverflow), .excUnderflow(excUnderflow)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: {inv, dz, ovf, unf, result}
  function automatic logic [35:0] refDiv(input logic [31:0] a, input logic [31:0] b);
    int ea = int'(a[30:23]);
    int eb = int'(b[30:23]);
    bit sgn = a[31] ^ b[31];
    bit aBad = (ea == 255) || (ea == 0 && a[22:0] != 0);
    bit bBad = (eb == 255) || (eb == 0 && b[22:0] != 0);
    longint ma, mb, num, q, r, m;
    int e;
    bit g, s;
    if (aBad || bBad) return {4'b1000, 32'h7FC00000};
    if (b[30:0] == 0) return {4'b0100, 32'h7FC00000};
    if (a[30:0] == 0) return {4'b0000, sgn, 31'd0};
    ma = longint'(a[22:0]) + (64'sd1 << 23);
    mb = longint'(b[22:0]) + (64'sd1 << 23);
    num = ma << 25;
    q = num / mb;
    r = num % mb;
    e = ea - eb + 127;
    if (q >= (64'sd1 << 25)) begin
      m = q >> 2; g = q[1]; s = q[0] || (r != 0);
    end else begin
      m = q >> 1; g = q[0]; s = (r != 0); e = e - 1;
    end
    if (g && (s || m[0])) m = m + 1;
    if (m == (64'sd1 << 24)) begin m = 64'sd1 << 23; e = e + 1; end
    if (e >= 255) return {4'b0010, sgn, 31'h7F800000};
    if (e <= 0) return {4'b0001, sgn, 31'd0};
    return {4'b0000, sgn, e[7:0], m[22:0]};
  endfunction

  // one operation, compared to the model on every cycle
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input string req, input bit poke);
    logic [35:0] expv = refDiv(a, b);
    bit spec = (expv[35:34] != 0) || (b[30:0] != 0 && a[30:0] == 0);
    int lat = spec ? 1 : 27;
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R10 busy after accept", {62'd0, busy, done}, 64'h2);
    for (int cyc = 1; cyc <= lat; cyc++) begin
      if (poke && cyc == 3) begin
        dividend = 32'h3F800000; divisor = 32'h40400000; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check(busy === (cyc < lat) && done === (cyc == lat),
            (spec ? "R6/R7 latency" : "R2 latency R10 busy"),
            {62'd0, busy, done}, {62'd0, cyc < lat, cyc == lat});
    end
    check({excInvalid, excDivZero, excOverflow, excUnderflow, quotient} === expv, req,
          {28'd0, excInvalid, excDivZero, excOverflow, excUnderflow, quotient}, {28'd0, expv});
  endtask

  function automatic logic [31:0] nextRand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, excInvalid, excDivZero, excOverflow, excUnderflow, quotient} === '0,
          "R11 reset", {26'd0, busy, done, excInvalid, excDivZero, excOverflow, excUnderflow, quotient}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(32'h40C00000, 32'h40000000, "R1 R4 6/2 no shift", 1'b0);
    runOp(32'h3F800000, 32'h40400000, "R4 R3 1/3 shifted and rounded", 1'b0);
    runOp(32'hC0F00000, 32'h40200000, "R1 sign -7.5/2.5", 1'b0);
    runOp(32'h3FFFFFFF, 32'h3F800001, "R3 near-two ratio", 1'b0);
    runOp(32'h3F800001, 32'h3FFFFFFF, "R3 R4 near-half ratio", 1'b0);
    runOp(32'h80000000, 32'h40000000, "R5 signed zero dividend", 1'b0);
    runOp(32'h3F800000, 32'h00000000, "R6 divide by zero", 1'b0);
    runOp(32'h00000000, 32'h80000000, "R6 zero over zero", 1'b0);
    runOp(32'h7F800000, 32'h3F800000, "R7 infinite dividend", 1'b0);
    runOp(32'h3F800000, 32'h7FC00001, "R7 NaN divisor", 1'b0);
    runOp(32'h00000001, 32'h00000000, "R7 subnormal over zero priority", 1'b0);
    runOp(32'h7F000000, 32'h3E800000, "R8 overflow", 1'b0);
    runOp(32'h7F7FFFFF, 32'h3F800000, "R8 largest finite kept", 1'b0);
    runOp(32'h80800000, 32'h40000000, "R9 underflow", 1'b0);
    runOp(32'h00800000, 32'h3F800000, "R9 smallest normal kept", 1'b0);
    runOp(32'h40490FDB, 32'h402DF854, "R10 start while busy ignored", 1'b1);
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a = nextRand();
      logic [31:0] b = nextRand();
      a[30:23] = 8'd64 + a[30:23] % 8'd128;
      b[30:23] = 8'd64 + b[30:23] % 8'd128;
      runOp(a, b, "R1 R3 R4 mixed operands", 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule